// File: doc/BRIEF.md
# DS3 Overhead Error Monitor

This block watches a received DS3 M-frame and reports the frame-level errors that its overhead carries. An upstream framer aligns the stream and tags each bit: frame start, payload, parity overhead, path-parity overhead and far-end-error overhead. The block does not count bits, so the frame length is whatever the framer marks between two starts. The block keeps a running modulo-2 sum of the payload of each frame. It then checks that sum against the parity bits carried in the frame that follows. It also decodes the three-bit far-end error code. On each frame boundary it issues one-cycle error pulses, and it raises a request for the transmitter to send a far-end error.

Each error type feeds a 16-bit saturating counter. The counters are read by a latch-and-clear strobe. A second path combines the line alarms (loss of signal, severely errored frame, loss of frame, alarm indication) through per-alarm enables into a remote-alarm level for the transmit side. A format select turns the path-parity and far-end checks on for C-bit framing and off for M23 framing.

Top module: `ds3_ovh_mon`

## Requirements
- R1: Only bits with `bit_vld_i=1` and `pay_mark_i=1` enter the frame parity. Overhead bits and cycles with `bit_vld_i=0` leave it unchanged. A frame runs from one valid `frm_start_i` bit, which belongs to the new frame, up to the next one.
- R2: The valid `frm_start_i` bit of frame N+1 closes frame N. In the cycle after that edge, `perr_o` pulses for one cycle if any bit marked by `pbit_mark_i` in frame N differs from the payload parity of frame N-1. The expected bit value is 1 when that parity is odd. There is exactly one pulse per frame, whether one or both parity bits are wrong.
- R3: With `cbit_mode_i=1`, `cperr_o` pulses once at the close of a frame if any bit marked by `cpar_mark_i` in that frame differs from the payload parity of the previous frame.
- R4: With `cbit_mode_i=1`, `febe_o` pulses once at the close of a frame if any of its three `febe_mark_i` bits is 0. The code 111 means no error.
- R5: With `cbit_mode_i=0` (M23), `cperr_o`, `febe_o` and `febe_tx_o` stay 0, and their counters do not advance.
- R6: With `cbit_mode_i=1`, `febe_tx_o` pulses at the close of a checked frame that had a path-parity mismatch, or that saw `frm_err_i` at any time during it.
- R7: `rai_o` is 1 one cycle after any alarm is high together with its enable bit, and 0 otherwise. The enable bits are `rai_en_i[0]` LOS, `[1]` SEF, `[2]` LOF and `[3]` AIS.
- R8: No pulse is issued for the first frame after reset, or after `lof_i` has been high, because no reference parity exists yet. While `lof_i` is high, frame tracking is held cleared.
- R9: Each error pulse advances its counter by one. A counter stops at all ones.
- R10: A `cnt_latch_i` cycle copies each running count to its `*_cnt_o` output and restarts the count. A pulse that falls in that same cycle is counted into the new period. Between strobes, the outputs hold.
- R11: After reset, all pulses, `rai_o` and the count outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld_i | input | 1 | Received bit strobe |
| bit_i | input | 1 | Received bit |
| frm_start_i | input | 1 | First bit of an M-frame |
| pay_mark_i | input | 1 | Bit is payload |
| pbit_mark_i | input | 1 | Bit is a frame parity bit |
| cpar_mark_i | input | 1 | Bit is a path parity bit |
| febe_mark_i | input | 1 | Bit is a far-end error code bit |
| cbit_mode_i | input | 1 | 1 = C-bit framing, 0 = M23 |
| frm_err_i | input | 1 | Framing error seen in this frame |
| los_i | input | 1 | Loss of signal |
| sef_i | input | 1 | Severely errored frame |
| lof_i | input | 1 | Loss of frame |
| ais_i | input | 1 | Alarm indication signal |
| rai_en_i | input | 4 | Per-alarm enables for the remote alarm |
| cnt_latch_i | input | 1 | Latch-and-clear strobe for the counters |
| perr_o | output | 1 | Frame parity error pulse |
| cperr_o | output | 1 | Path parity error pulse |
| febe_o | output | 1 | Far-end error pulse |
| febe_tx_o | output | 1 | Request to send a far-end error |
| rai_o | output | 1 | Remote alarm level |
| perr_cnt_o | output | CNT_W | Latched frame parity error count |
| cperr_cnt_o | output | CNT_W | Latched path parity error count |
| febe_cnt_o | output | CNT_W | Latched far-end error count |

## Verification
The hardest case to reach from the ports is a latch strobe that lands in the very cycle an error pulse is presented to a counter. A second hard case is an error that lies one frame behind its reference. The bench therefore acts as the framer itself: it builds short frames with its own position marks and flips chosen overhead bits relative to the parity it tracked for the previous frame. It places the strobe in the cycle after a frame start, which is exactly where a pulse appears. Each phase opens with a loss-of-frame cycle and a deliberately corrupted first frame, so that suppression is exercised every time. A narrow counter width lets saturation be reached in a few dozen frames.

// File: rtl/ds3_ovh_pkg.sv
package ds3_ovh_pkg;

  localparam int unsigned NUM_ERR = 3;
  localparam int unsigned NUM_ALM = 4;

  typedef enum logic [1:0] {
    ERR_PBIT = 2'd0,
    ERR_CBIT = 2'd1,
    ERR_FEBE = 2'd2
  } err_kind_e;

  typedef enum logic [1:0] {
    ALM_LOS = 2'd0,
    ALM_SEF = 2'd1,
    ALM_LOF = 2'd2,
    ALM_AIS = 2'd3
  } alm_e;

  // per-frame tracking state
  typedef struct packed {
    logic inf;      // a frame start has been seen
    logic ref_vld;  // ref_par belongs to a complete frame
    logic ref_par;  // payload parity of the previous frame
    logic acc;      // running payload parity of the current frame
    logic pmis;     // frame parity bit mismatch seen
    logic cmis;     // path parity bit mismatch seen
    logic fzero;    // a zero in the far-end error code
    logic ferr;     // framing error during this frame
  } trk_t;

endpackage

// File: rtl/ds3_par_trk.sv
module ds3_par_trk
  import ds3_ovh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_vld_i,
  input  logic               bit_i,
  input  logic               frm_start_i,
  input  logic               pay_mark_i,
  input  logic               pbit_mark_i,
  input  logic               cpar_mark_i,
  input  logic               febe_mark_i,
  input  logic               cbit_mode_i,
  input  logic               frm_err_i,
  input  logic               lof_i,
  output logic [NUM_ERR-1:0] fire_o,
  output logic               tx_o
);

  trk_t               st_q, st_d;
  logic [NUM_ERR-1:0] fire_d;
  logic               tx_d;
  logic               close;
  logic               eval;
  logic               st_en;

  always_comb begin
    close  = bit_vld_i && frm_start_i && !lof_i;
    eval   = close && st_q.inf && st_q.ref_vld;
    fire_d = '0;
    tx_d   = 1'b0;
    if (eval) begin
      fire_d[ERR_PBIT] = st_q.pmis;
      fire_d[ERR_CBIT] = cbit_mode_i && st_q.cmis;
      fire_d[ERR_FEBE] = cbit_mode_i && st_q.fzero;
      tx_d             = cbit_mode_i && (st_q.cmis || st_q.ferr);
    end
  end

  always_comb begin
    st_d  = st_q;
    st_en = lof_i || bit_vld_i || frm_err_i;
    if (lof_i) begin
      st_d = '0;
    end else if (close) begin
      st_d.inf     = 1'b1;
      st_d.ref_vld = st_q.inf;
      st_d.ref_par = st_q.acc;
      st_d.acc     = pay_mark_i & bit_i;
      st_d.pmis    = pbit_mark_i & (bit_i ^ st_q.acc);
      st_d.cmis    = cpar_mark_i & (bit_i ^ st_q.acc);
      st_d.fzero   = febe_mark_i & ~bit_i;
      st_d.ferr    = frm_err_i;
    end else begin
      if (bit_vld_i) begin
        st_d.acc   = st_q.acc ^ (pay_mark_i & bit_i);
        st_d.pmis  = st_q.pmis | (pbit_mark_i & (bit_i ^ st_q.ref_par));
        st_d.cmis  = st_q.cmis | (cpar_mark_i & (bit_i ^ st_q.ref_par));
        st_d.fzero = st_q.fzero | (febe_mark_i & ~bit_i);
      end
      st_d.ferr = st_q.ferr | frm_err_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      fire_o <= '0;
      tx_o   <= 1'b0;
    end else begin
      if (st_en) begin
        st_q <= st_d;
      end
      fire_o <= fire_d;
      tx_o   <= tx_d;
    end
  end

endmodule

// File: rtl/ds3_sat_cnt.sv
module ds3_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] run_q, run_d;
  logic [W-1:0] snap_d;
  logic         full;
  logic         run_en;

  always_comb begin
    full   = &run_q;
    run_en = clr_i || (inc_i && !full);
    snap_d = cnt_o;
    if (clr_i) begin
      snap_d = run_q;
      run_d  = inc_i ? ONE : '0;
    end else begin
      run_d  = run_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      cnt_o <= '0;
    end else begin
      if (run_en) begin
        run_q <= run_d;
      end
      if (clr_i) begin
        cnt_o <= snap_d;
      end
    end
  end

endmodule

// File: rtl/ds3_rai_gen.sv
module ds3_rai_gen #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alm_i,
  input  logic [N-1:0] en_i,
  output logic         rai_o
);

  logic rai_d;

  always_comb begin
    rai_d = |(alm_i & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rai_o <= 1'b0;
    end else begin
      rai_o <= rai_d;
    end
  end

endmodule

// File: rtl/ds3_ovh_mon.sv
module ds3_ovh_mon
  import ds3_ovh_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             frm_start_i,
  input  logic             pay_mark_i,
  input  logic             pbit_mark_i,
  input  logic             cpar_mark_i,
  input  logic             febe_mark_i,
  input  logic             cbit_mode_i,
  input  logic             frm_err_i,
  input  logic             los_i,
  input  logic             sef_i,
  input  logic             lof_i,
  input  logic             ais_i,
  input  logic [3:0]       rai_en_i,
  input  logic             cnt_latch_i,
  output logic             perr_o,
  output logic             cperr_o,
  output logic             febe_o,
  output logic             febe_tx_o,
  output logic             rai_o,
  output logic [CNT_W-1:0] perr_cnt_o,
  output logic [CNT_W-1:0] cperr_cnt_o,
  output logic [CNT_W-1:0] febe_cnt_o
);

  logic [1:0]         rst_sync_q;
  logic               rst_q_n;
  logic [NUM_ERR-1:0] fire;
  logic [NUM_ALM-1:0] alm;
  logic [CNT_W-1:0]   cnt_arr [NUM_ERR];

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  ds3_par_trk u_trk (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .bit_vld_i   (bit_vld_i),
    .bit_i       (bit_i),
    .frm_start_i (frm_start_i),
    .pay_mark_i  (pay_mark_i),
    .pbit_mark_i (pbit_mark_i),
    .cpar_mark_i (cpar_mark_i),
    .febe_mark_i (febe_mark_i),
    .cbit_mode_i (cbit_mode_i),
    .frm_err_i   (frm_err_i),
    .lof_i       (lof_i),
    .fire_o      (fire),
    .tx_o        (febe_tx_o)
  );

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_cnt
    ds3_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_q_n),
      .inc_i (fire[g]),
      .clr_i (cnt_latch_i),
      .cnt_o (cnt_arr[g])
    );
  end

  always_comb begin
    alm          = '0;
    alm[ALM_LOS] = los_i;
    alm[ALM_SEF] = sef_i;
    alm[ALM_LOF] = lof_i;
    alm[ALM_AIS] = ais_i;
  end

  ds3_rai_gen #(.N(NUM_ALM)) u_rai (
    .clk   (clk),
    .rst_n (rst_q_n),
    .alm_i (alm),
    .en_i  (rai_en_i),
    .rai_o (rai_o)
  );

  assign perr_o      = fire[ERR_PBIT];
  assign cperr_o     = fire[ERR_CBIT];
  assign febe_o      = fire[ERR_FEBE];
  assign perr_cnt_o  = cnt_arr[ERR_PBIT];
  assign cperr_cnt_o = cnt_arr[ERR_CBIT];
  assign febe_cnt_o  = cnt_arr[ERR_FEBE];

endmodule

// File: rtl/ds3_ovh_mon_chk.sv
module ds3_ovh_mon_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             bit_vld_i,
  input logic             frm_start_i,
  input logic             cbit_mode_i,
  input logic             lof_i,
  input logic             los_i,
  input logic             sef_i,
  input logic             ais_i,
  input logic [3:0]       rai_en_i,
  input logic             cnt_latch_i,
  input logic             perr_o,
  input logic             cperr_o,
  input logic             febe_o,
  input logic             febe_tx_o,
  input logic             rai_o,
  input logic [CNT_W-1:0] perr_cnt_o,
  input logic [CNT_W-1:0] cperr_cnt_o,
  input logic [CNT_W-1:0] febe_cnt_o
);

  logic [3:0] alm_v;
  assign alm_v = {ais_i, lof_i, sef_i, los_i};

  // R2
  perr_at_close_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    perr_o |-> $past(frm_start_i && bit_vld_i && !lof_i));

  // R5
  m23_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cbit_mode_i |=> (!cperr_o && !febe_o && !febe_tx_o));

  // R6
  tx_at_close_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    febe_tx_o |-> $past(frm_start_i && bit_vld_i));

  // R7
  rai_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|(alm_v & rai_en_i)) |=> rai_o);

  // R7
  rai_clr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(|(alm_v & rai_en_i)) |=> !rai_o);

  // R8
  lof_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    lof_i |=> (!perr_o && !cperr_o && !febe_o && !febe_tx_o));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cnt_latch_i |=> ($stable(perr_cnt_o) && $stable(cperr_cnt_o) && $stable(febe_cnt_o)));

endmodule

bind ds3_ovh_mon ds3_ovh_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .bit_vld_i   (bit_vld_i),
  .frm_start_i (frm_start_i),
  .cbit_mode_i (cbit_mode_i),
  .lof_i       (lof_i),
  .los_i       (los_i),
  .sef_i       (sef_i),
  .ais_i       (ais_i),
  .rai_en_i    (rai_en_i),
  .cnt_latch_i (cnt_latch_i),
  .perr_o      (perr_o),
  .cperr_o     (cperr_o),
  .febe_o      (febe_o),
  .febe_tx_o   (febe_tx_o),
  .rai_o       (rai_o),
  .perr_cnt_o  (perr_cnt_o),
  .cperr_cnt_o (cperr_cnt_o),
  .febe_cnt_o  (febe_cnt_o)
);

// File: tb/tb_ds3_ovh_mon.sv
module tb_ds3_ovh_mon;

  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld_i = 0, bit_i = 0, frm_start_i = 0, pay_mark_i = 0;
  logic pbit_mark_i = 0, cpar_mark_i = 0, febe_mark_i = 0, cbit_mode_i = 0;
  logic frm_err_i = 0, los_i = 0, sef_i = 0, lof_i = 0, ais_i = 0;
  logic [3:0] rai_en_i = 4'h0;
  logic cnt_latch_i = 0;
  logic perr_o, cperr_o, febe_o, febe_tx_o, rai_o;
  logic [CW-1:0] perr_cnt_o, cperr_cnt_o, febe_cnt_o;

  always #5 clk = ~clk;

  ds3_ovh_mon #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .frm_start_i(frm_start_i), .pay_mark_i(pay_mark_i), .pbit_mark_i(pbit_mark_i),
    .cpar_mark_i(cpar_mark_i), .febe_mark_i(febe_mark_i), .cbit_mode_i(cbit_mode_i),
    .frm_err_i(frm_err_i), .los_i(los_i), .sef_i(sef_i), .lof_i(lof_i), .ais_i(ais_i),
    .rai_en_i(rai_en_i), .cnt_latch_i(cnt_latch_i), .perr_o(perr_o), .cperr_o(cperr_o),
    .febe_o(febe_o), .febe_tx_o(febe_tx_o), .rai_o(rai_o), .perr_cnt_o(perr_cnt_o),
    .cperr_cnt_o(cperr_cnt_o), .febe_cnt_o(febe_cnt_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_started, m_haveref, m_refpar, m_par, m_pbad, m_cbad, m_fbad, m_ferr;
  int m_perr, m_cperr, m_febe, m_tx, m_rai;
  int m_run[3];
  int m_snap[3];
  int m_pulse[3];
  int m_closing;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_started = 0; m_haveref = 0; m_refpar = 0; m_par = 0;
      m_pbad = 0; m_cbad = 0; m_fbad = 0; m_ferr = 0;
      m_perr = 0; m_cperr = 0; m_febe = 0; m_tx = 0; m_rai = 0;
      for (int k = 0; k < 3; k++) begin m_run[k] = 0; m_snap[k] = 0; end
    end else begin
      // counters see the pulses presented during this cycle (R9, R10)
      m_pulse[0] = m_perr; m_pulse[1] = m_cperr; m_pulse[2] = m_febe;
      for (int k = 0; k < 3; k++) begin
        if (cnt_latch_i) begin
          m_snap[k] = m_run[k];
          m_run[k]  = m_pulse[k];
        end else if (m_pulse[k] != 0 && m_run[k] < CMAX) begin
          m_run[k]++;
        end
      end
      // R7
      m_rai = ((los_i & rai_en_i[0]) | (sef_i & rai_en_i[1]) |
               (lof_i & rai_en_i[2]) | (ais_i & rai_en_i[3])) ? 1 : 0;
      m_closing = (bit_vld_i && frm_start_i && !lof_i) ? 1 : 0;
      m_perr = 0; m_cperr = 0; m_febe = 0; m_tx = 0;
      if (m_closing != 0 && m_started != 0 && m_haveref != 0) begin
        m_perr  = m_pbad;
        m_cperr = cbit_mode_i ? m_cbad : 0;
        m_febe  = cbit_mode_i ? m_fbad : 0;
        m_tx    = (cbit_mode_i && (m_cbad != 0 || m_ferr != 0)) ? 1 : 0;
      end
      if (lof_i) begin
        m_started = 0; m_haveref = 0; m_refpar = 0; m_par = 0;
        m_pbad = 0; m_cbad = 0; m_fbad = 0; m_ferr = 0;
      end else begin
        if (m_closing != 0) begin
          m_haveref = m_started;
          m_started = 1;
          m_refpar  = m_par;
          m_par = 0; m_pbad = 0; m_cbad = 0; m_fbad = 0; m_ferr = 0;
        end
        if (bit_vld_i) begin
          if (pay_mark_i) m_par ^= int'(bit_i);
          if (pbit_mark_i && int'(bit_i) != m_refpar) m_pbad = 1;
          if (cpar_mark_i && int'(bit_i) != m_refpar) m_cbad = 1;
          if (febe_mark_i && !bit_i) m_fbad = 1;
        end
        if (frm_err_i) m_ferr = 1;
      end
    end
  end

  int tx_seen = 0;

  always @(negedge clk) begin
    if (!done) begin
      chk("R2 perr_o", int'(perr_o), m_perr);
      chk("R3 cperr_o", int'(cperr_o), m_cperr);
      chk("R4 febe_o", int'(febe_o), m_febe);
      chk("R6 febe_tx_o", int'(febe_tx_o), m_tx);
      chk("R7 rai_o", int'(rai_o), m_rai);
      chk("R9 perr_cnt_o", int'(perr_cnt_o), m_snap[0]);
      chk("R9 cperr_cnt_o", int'(cperr_cnt_o), m_snap[1]);
      chk("R9 febe_cnt_o", int'(febe_cnt_o), m_snap[2]);
      if (febe_tx_o) tx_seen++;
    end
  end

  // ---------------- stimulus ----------------
  int prev_par = 0;
  int fidx = 0;
  int e_p, e_c, e_f, e_t;

  task automatic drive(input bit s, input bit v, input bit b, input bit py,
                       input bit pm, input bit cm, input bit fm, input bit fe,
                       input bit lat);
    frm_start_i = s; bit_vld_i = v; bit_i = b; pay_mark_i = py;
    pbit_mark_i = pm; cpar_mark_i = cm; febe_mark_i = fm;
    frm_err_i = fe; cnt_latch_i = lat;
    @(negedge clk);
  endtask

  task automatic idle(input bit lat);
    drive(0, 0, 0, 0, 0, 0, 0, 0, lat);
  endtask

  task automatic sat_inc(inout int v);
    if (v < CMAX) v++;
  endtask

  // one short frame; flips are relative to the previous frame's payload parity
  task automatic send_frame(input logic [15:0] pay, input logic [1:0] pfl,
                            input logic [2:0] cfl, input logic [2:0] fv,
                            input bit fe, input bit lat);
    bit pp = prev_par[0];
    drive(1, 1, 1, 0, 0, 0, 0, 0, 0);           // start, unmarked overhead 1 (R1)
    drive(0, 1, pp ^ pfl[0], 0, 1, 0, 0, 0, lat);
    drive(0, 0, 1, 1, 0, 0, 0, 0, 0);           // invalid payload-marked 1 (R1)
    for (int i = 0; i < 8; i++) drive(0, 1, pay[i], 1, 0, 0, 0, 0, 0);
    drive(0, 1, pp ^ pfl[1], 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) drive(0, 1, pp ^ cfl[i], 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) drive(0, 1, fv[i], 0, 0, 0, 1, 0, 0);
    drive(0, 1, 1'b0, 0, 0, 0, 0, fe, 0);
    for (int i = 8; i < 16; i++) drive(0, 1, pay[i], 1, 0, 0, 0, 0, 0);
    if (fidx >= 1) begin
      if (pfl != 0) sat_inc(e_p);
      if (cbit_mode_i && cfl != 0) sat_inc(e_c);
      if (cbit_mode_i && fv != 3'b111) sat_inc(e_f);
      if (cbit_mode_i && (cfl != 0 || fe)) e_t++;
    end
    prev_par = int'(^pay);
    fidx++;
  endtask

  task automatic phase_begin(input bit cb);
    cbit_mode_i = cb;
    lof_i = 1'b1;
    idle(0);
    lof_i = 1'b0;
    idle(1);                                     // clear running counts
    idle(0);
    fidx = 0; e_p = 0; e_c = 0; e_f = 0; e_t = 0;
    tx_seen = 0;
  endtask

  task automatic phase_end(input string tag);
    send_frame(16'h0000, 2'b00, 3'b000, 3'b111, 1'b0, 1'b0);  // closer
    idle(0);
    idle(1);
    idle(0);
    chk({tag, " R2 R9 perr count"}, int'(perr_cnt_o), e_p);
    chk({tag, " R3 R9 cperr count"}, int'(cperr_cnt_o), e_c);
    chk({tag, " R4 R9 febe count"}, int'(febe_cnt_o), e_f);
    chk({tag, " R6 tx pulses"}, tx_seen, e_t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 perr_o", int'(perr_o), 0);
    chk("R11 rai_o", int'(rai_o), 0);
    chk("R11 perr_cnt_o", int'(perr_cnt_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // C-bit mode: mixed errors; first frame corrupted but suppressed (R8)
    phase_begin(1'b1);
    send_frame(16'hA5C3, 2'b11, 3'b111, 3'b000, 1'b1, 1'b0);
    send_frame(16'h0001, 2'b01, 3'b000, 3'b111, 1'b0, 1'b0);
    send_frame(16'h8421, 2'b10, 3'b000, 3'b111, 1'b0, 1'b0);
    send_frame(16'h7FFF, 2'b11, 3'b001, 3'b111, 1'b0, 1'b0);
    send_frame(16'h1234, 2'b00, 3'b000, 3'b011, 1'b0, 1'b0);
    send_frame(16'hFFFF, 2'b00, 3'b100, 3'b110, 1'b0, 1'b0);
    send_frame(16'h0F0F, 2'b00, 3'b000, 3'b111, 1'b1, 1'b0);
    send_frame(16'h3C01, 2'b00, 3'b000, 3'b111, 1'b0, 1'b0);
    phase_end("cbit");
    chk("R8 R2 first frame suppressed, perr count", int'(perr_cnt_o), 3);

    // M23 mode: path parity and far-end ignored (R5)
    phase_begin(1'b0);
    send_frame(16'h5555, 2'b11, 3'b111, 3'b000, 1'b1, 1'b0);
    send_frame(16'h0003, 2'b01, 3'b111, 3'b000, 1'b1, 1'b0);
    send_frame(16'hC001, 2'b00, 3'b010, 3'b101, 1'b0, 1'b0);
    phase_end("m23");
    chk("R5 cperr count in M23", int'(cperr_cnt_o), 0);
    chk("R5 febe count in M23", int'(febe_cnt_o), 0);

    // latch strobe in the pulse cycle (R10)
    phase_begin(1'b1);
    send_frame(16'h0101, 2'b00, 3'b000, 3'b111, 1'b0, 1'b0);
    send_frame(16'h0011, 2'b01, 3'b000, 3'b111, 1'b0, 1'b0);
    send_frame(16'h0007, 2'b01, 3'b000, 3'b111, 1'b0, 1'b1);
    chk("R10 snapshot excludes same-cycle pulse", int'(perr_cnt_o), 0);
    phase_end("latch");

    // saturation (R9)
    phase_begin(1'b1);
    for (int i = 0; i < 20; i++)
      send_frame(16'(i * 16'h0137), 2'b01, 3'b000, 3'b111, 1'b0, 1'b0);
    phase_end("sat");
    chk("R9 saturated at all ones", int'(perr_cnt_o), CMAX);

    // RAI enables (R7)
    for (int en = 0; en < 16; en++) begin
      for (int a = 0; a < 16; a++) begin
        rai_en_i = 4'(en);
        {ais_i, lof_i, sef_i, los_i} = 4'(a);
        idle(0);
        chk("R7 rai level", int'(rai_o), ((en & a) != 0) ? 1 : 0);
      end
    end
    {ais_i, lof_i, sef_i, los_i} = 4'h0;
    idle(0);
    idle(0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule